// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns one buffer of bytes into a single HDLC frame on a serial line. A frame is an optional 16-bit alternating preamble, one opening flag, the payload sent least-significant bit first, a 16-bit frame check sequence and one closing flag. A zero is inserted after any run of five ones in the payload and check sequence. Between frames the line rests at the ones level and carries no flags. Every frame has its own pair of flags.

A client loads a byte count with a start pulse while `ready` is high. The block then fetches each byte with a one-clock `byte_rd` pulse and samples `byte_data` in that same clock. All line timing follows `tick16`, which pulses sixteen times per bit. The line can be Manchester coded, inverted, or both. The mode inputs are taken only while `tx_en` is low, so they are set first and the transmitter is enabled last. A clear-to-send input holds a queued frame back. A one-clock `done` pulse marks the end of each frame.

Top module: `hdlc_tx`

## Requirements
- R1: While reset is held or `tx_en` is low, `busy`, `ready` and `done` are 0 and `tx_line` sits at the idle level. The idle level is 1, or 0 when inversion was selected.
- R2: A frame is sent in this order: opening flag 0x7E, the payload bytes in order each LSB first, the check sequence, and closing flag 0x7E. Each frame has exactly one flag of each kind, and the line returns to idle afterwards.
- R3: When `cfg_preamble` is 1, sixteen bits 0,1,0,1,... (starting with 0) come before the opening flag. When it is 0 there is no preamble.
- R4: After five consecutive ones in the payload or check sequence, a 0 is inserted. This includes a run that ends at the last check-sequence bit. No insertion happens inside flags or the preamble.
- R5: The check sequence uses polynomial x^16+x^12+x^5+1 in reflected form (0x8408), preset to 0xFFFF and run over the payload bits. It is sent complemented, bit 0 first.
- R6: Each bit lasts exactly 16 `tick16` pulses, whatever the spacing of those pulses in clocks.
- R7: When `cfg_manchester` is 1, each frame bit is sent as two halves of 8 ticks each. The first half carries the complement of the bit and the second half carries the bit. The idle line is not coded.
- R8: When `cfg_invert` is 1, the whole line, idle included, is the complement of the non-inverted line.
- R9: While `cts` is 0, a queued frame does not begin: the line stays idle and `busy` stays 1. The frame starts after `cts` rises.
- R10: `done` is high for exactly one clock after the last closing-flag bit period ends. In that clock the line is already idle.
- R11: The mode inputs are captured only while `tx_en` is 0. Changing them while enabled has no effect on the line.
- R12: `ready` = `tx_en` and no frame queued or in progress. A start while ready is accepted and raises `busy`. Exactly `len` bytes are fetched. With `len` = 0 the frame carries only the check sequence (0x0000 after complement of 0xFFFF... sent as computed over no bits).
- R13: Dropping `tx_en` during a frame aborts it. From the next clock the line is idle and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; mode inputs are captured while low |
| cts | input | 1 | Clear to send; a frame may begin only while high |
| tick16 | input | 1 | Clock enable at sixteen times the bit rate |
| cfg_preamble | input | 1 | Send the 16-bit alternating preamble |
| cfg_manchester | input | 1 | Manchester-code frame bits |
| cfg_invert | input | 1 | Invert the line |
| start | input | 1 | Queue a frame of `len` bytes (taken while `ready`) |
| len | input | LEN_W | Payload length in bytes |
| ready | output | 1 | A start would be accepted |
| byte_data | input | 8 | Payload byte, sampled in the clock `byte_rd` is high |
| byte_rd | output | 1 | Fetch pulse for the next payload byte |
| tx_line | output | 1 | Serial line |
| busy | output | 1 | A frame is queued or in progress |
| done | output | 1 | One-clock pulse when the closing flag has been sent |

## Verification
Counting bytes exercise the general path and the check sequence with mixed data. Bytes of 0xFF force zero insertion on every fifth bit, across byte boundaries and into the check sequence. Bytes equal to 0x7E show that payload flag patterns are broken up by insertion. All-zero payloads and the empty frame show that no insertion occurs where none is due, and that a frame can carry nothing but the check sequence. The same patterns are repeated with preamble, Manchester coding, inversion and widely spaced ticks, so that any one option can be told apart from the framing itself.

// File: rtl/hdlc_tx_pkg.sv
// Shared definitions for the HDLC transmitter: sequencer states, the flag
// pattern, the check-sequence polynomial and framing lengths.
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE,
        ST_FIN
    } tx_state_t;

    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [15:0] FCS_POLY   = 16'h8408;
    localparam logic [15:0] FCS_INIT   = 16'hFFFF;
    localparam int          PRE_BITS   = 16;
    localparam int          FCS_BITS   = 16;
    localparam int          STUFF_RUN  = 5;

endpackage

// File: rtl/hdlc_tx_crc.sv
// Bit-serial reflected CRC register.
// Assumes: data bits arrive LSB first; clr has priority over upd.
module hdlc_tx_crc #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] POLY  = 16'h8408,
    parameter logic [WIDTH-1:0] INIT  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic             din,
    output logic [WIDTH-1:0] crc
);

    logic fb;

    // Feedback bit of the reflected shift register
    assign fb = crc[0] ^ din;

    // Preset on clear, shift one data bit per update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc <= INIT;
        end else if (upd) begin
            crc <= (crc >> 1) ^ (fb ? POLY : '0);
        end
    end

endmodule

// File: rtl/hdlc_tx_line.sv
// Bit timing and line coding. Counts tick pulses into bit periods, raises a
// strobe at the end of each period, and forms the line level from the current
// bit with optional Manchester coding and inversion.
// Assumes: cur_bit/frame_bit change only on strobe; idle bits are never coded.
module hdlc_tx_line #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic man_en,
    input  logic inv_en,
    input  logic cur_bit,
    input  logic frame_bit,
    output logic strobe,
    output logic line
);

    localparam int PH_W = $clog2(OSR);
    localparam int HALF = OSR / 2;

    logic [PH_W-1:0] ph;
    logic            second_half;
    logic            sym;

    // Phase within the bit period
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ph <= '0;
        end else if (tick) begin
            ph <= (ph == PH_W'(OSR - 1)) ? '0 : ph + 1'b1;
        end
    end

    // End of a bit period
    assign strobe      = en && tick && (ph == PH_W'(OSR - 1));
    assign second_half = (ph >= PH_W'(HALF));

    // Manchester: complement in first half, true bit in second half
    always_comb begin
        if (frame_bit && man_en) begin
            sym = second_half ? cur_bit : ~cur_bit;
        end else begin
            sym = cur_bit;
        end
    end

    assign line = sym ^ inv_en;

endmodule

// File: rtl/hdlc_tx_framer.sv
// Frame sequencer. On each bit strobe it picks the next line bit: idle ones,
// preamble, flags, payload with zero insertion, complemented check sequence.
// Assumes: byte_data is valid in the clock byte_rd is high; crc is stable
// while the check sequence is sent.
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             strobe,
    input  logic             pending,
    input  logic             cts,
    input  logic             pre_en,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       byte_data,
    input  logic [15:0]      crc,
    output logic             byte_rd,
    output logic             launch,
    output logic             crc_clr,
    output logic             crc_upd,
    output logic             crc_bit,
    output logic             cur_bit,
    output logic             frame_bit,
    output logic             done,
    output logic             in_idle
);

    tx_state_t        st;
    logic [3:0]       idx;
    logic [2:0]       ones;
    logic [7:0]       sh;
    logic [LEN_W-1:0] cnt;
    logic             stuff;
    logic             fcs_bit;

    // Run of five ones reached: next bit is an inserted zero
    assign stuff   = (ones == 3'(STUFF_RUN));
    assign fcs_bit = ~crc[idx];

    // Frame begins on a bit boundary once queued and cleared to send
    assign launch  = strobe && (st == ST_IDLE) && pending && cts;
    assign crc_clr = launch;
    assign crc_upd = strobe && (st == ST_DATA) && !stuff;
    assign crc_bit = sh[0];
    assign in_idle = (st == ST_IDLE);

    // Byte fetch: after the opening flag, and at the end of each non-final byte
    assign byte_rd = strobe && (
        ((st == ST_OPEN) && (idx == 4'd7) && (cnt != '0)) ||
        ((st == ST_DATA) && !stuff && (idx == 4'd7) && (cnt != LEN_W'(1))));

    // Sequencer: select and register the next line bit on every strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st        <= ST_IDLE;
            idx       <= '0;
            ones      <= '0;
            sh        <= '0;
            cnt       <= '0;
            cur_bit   <= 1'b1;
            frame_bit <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (strobe) begin
                case (st)
                    ST_IDLE: begin
                        cur_bit   <= 1'b1;
                        frame_bit <= 1'b0;
                        if (pending && cts) begin
                            st  <= pre_en ? ST_PRE : ST_OPEN;
                            idx <= '0;
                            cnt <= len;
                        end
                    end
                    ST_PRE: begin
                        cur_bit   <= idx[0];
                        frame_bit <= 1'b1;
                        if (idx == 4'(PRE_BITS - 1)) begin
                            st  <= ST_OPEN;
                            idx <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    ST_OPEN: begin
                        cur_bit   <= FLAG_BYTE[idx[2:0]];
                        frame_bit <= 1'b1;
                        if (idx == 4'd7) begin
                            idx  <= '0;
                            ones <= '0;
                            if (cnt == '0) begin
                                st <= ST_FCS;
                            end else begin
                                st <= ST_DATA;
                                sh <= byte_data;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        frame_bit <= 1'b1;
                        if (stuff) begin
                            cur_bit <= 1'b0;
                            ones    <= '0;
                        end else begin
                            cur_bit <= sh[0];
                            ones    <= sh[0] ? ones + 1'b1 : '0;
                            if (idx == 4'd7) begin
                                idx <= '0;
                                cnt <= cnt - 1'b1;
                                if (cnt == LEN_W'(1)) begin
                                    st <= ST_FCS;
                                end else begin
                                    sh <= byte_data;
                                end
                            end else begin
                                sh  <= sh >> 1;
                                idx <= idx + 1'b1;
                            end
                        end
                    end
                    ST_FCS: begin
                        frame_bit <= 1'b1;
                        if (stuff) begin
                            cur_bit <= 1'b0;
                            ones    <= '0;
                        end else begin
                            cur_bit <= fcs_bit;
                            ones    <= fcs_bit ? ones + 1'b1 : '0;
                            if (idx == 4'(FCS_BITS - 1)) begin
                                st  <= ST_CLOSE;
                                idx <= '0;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end
                    end
                    ST_CLOSE: begin
                        frame_bit <= 1'b1;
                        if ((idx == 4'd0) && stuff) begin
                            cur_bit <= 1'b0;
                            ones    <= '0;
                        end else begin
                            cur_bit <= FLAG_BYTE[idx[2:0]];
                            ones    <= '0;
                            if (idx == 4'd7) begin
                                st  <= ST_FIN;
                                idx <= '0;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end
                    end
                    default: begin
                        cur_bit   <= 1'b1;
                        frame_bit <= 1'b0;
                        done      <= 1'b1;
                        st        <= ST_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/hdlc_tx.sv
// HDLC frame transmitter top. Captures the mode inputs while disabled, queues
// one frame per accepted start, and joins the sequencer, CRC and line coder.
// Assumes: modes are set before tx_en rises; one frame is queued at a time.
module hdlc_tx
    import hdlc_tx_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             cts,
    input  logic             tick16,
    input  logic             cfg_preamble,
    input  logic             cfg_manchester,
    input  logic             cfg_invert,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             ready,
    input  logic [7:0]       byte_data,
    output logic             byte_rd,
    output logic             tx_line,
    output logic             busy,
    output logic             done
);

    logic             pre_q;
    logic             man_q;
    logic             inv_q;
    logic             pending;
    logic [LEN_W-1:0] len_q;
    logic             accept;
    logic             launch;
    logic             in_idle;
    logic             strobe;
    logic             cur_bit;
    logic             frame_bit;
    logic             crc_clr;
    logic             crc_upd;
    logic             crc_bit;
    logic [15:0]      crc;

    // Mode capture, only while the transmitter is disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= 1'b0;
            man_q <= 1'b0;
            inv_q <= 1'b0;
        end else if (!tx_en) begin
            pre_q <= cfg_preamble;
            man_q <= cfg_manchester;
            inv_q <= cfg_invert;
        end
    end

    assign ready  = tx_en && !pending && in_idle;
    assign accept = start && ready;
    assign busy   = pending || !in_idle;

    // Frame queue: one pending request with its length
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            pending <= 1'b0;
            len_q   <= '0;
        end else if (accept) begin
            pending <= 1'b1;
            len_q   <= len;
        end else if (launch) begin
            pending <= 1'b0;
        end
    end

    hdlc_tx_crc #(
        .WIDTH (16),
        .POLY  (FCS_POLY),
        .INIT  (FCS_INIT)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .upd   (crc_upd),
        .din   (crc_bit),
        .crc   (crc)
    );

    hdlc_tx_framer #(
        .LEN_W (LEN_W)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .strobe    (strobe),
        .pending   (pending),
        .cts       (cts),
        .pre_en    (pre_q),
        .len       (len_q),
        .byte_data (byte_data),
        .crc       (crc),
        .byte_rd   (byte_rd),
        .launch    (launch),
        .crc_clr   (crc_clr),
        .crc_upd   (crc_upd),
        .crc_bit   (crc_bit),
        .cur_bit   (cur_bit),
        .frame_bit (frame_bit),
        .done      (done),
        .in_idle   (in_idle)
    );

    hdlc_tx_line #(
        .OSR (OSR)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .tick      (tick16),
        .man_en    (man_q),
        .inv_en    (inv_q),
        .cur_bit   (cur_bit),
        .frame_bit (frame_bit),
        .strobe    (strobe),
        .line      (tx_line)
    );

endmodule

// File: rtl/hdlc_tx_chk.sv
// Protocol checker for hdlc_tx, attached to every instance by bind.
// Assumes: visibility of the captured mode registers of the top.
module hdlc_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic start,
    input logic ready,
    input logic busy,
    input logic byte_rd,
    input logic done,
    input logic tx_line,
    input logic inv_q,
    input logic man_q,
    input logic pre_q
);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tx_line == !inv_q));

    a_r13_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> ((tx_line == !inv_q) && !busy));

    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> ($stable(man_q) && $stable(inv_q) && $stable(pre_q)));

    a_r12_fetch_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        byte_rd |-> busy);

    a_r12_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> busy);

endmodule

bind hdlc_tx hdlc_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .start   (start),
    .ready   (ready),
    .busy    (busy),
    .byte_rd (byte_rd),
    .done    (done),
    .tx_line (tx_line),
    .inv_q   (inv_q),
    .man_q   (man_q),
    .pre_q   (pre_q)
);

// File: tb/hdlc_tx_test.sv
module hdlc_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // fields: [15:8] length, [7:6] pattern, [5] preamble, [4] manchester, [3] invert, [2:0] tick spacing
    localparam logic [15:0] VEC [NV] = '{
        {8'd5, 2'd1, 1'b0, 1'b0, 1'b0, 3'd1},
        {8'd4, 2'd0, 1'b0, 1'b0, 1'b0, 3'd1},
        {8'd3, 2'd2, 1'b1, 1'b0, 1'b0, 3'd1},
        {8'd6, 2'd1, 1'b1, 1'b1, 1'b0, 3'd1},
        {8'd2, 2'd0, 1'b0, 1'b1, 1'b1, 3'd2},
        {8'd0, 2'd3, 1'b0, 1'b0, 1'b1, 3'd1},
        {8'd8, 2'd3, 1'b1, 1'b0, 1'b0, 3'd3},
        {8'd1, 2'd1, 1'b0, 1'b1, 1'b0, 3'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       cts = 1'b1;
    logic       tick16 = 1'b1;
    logic       cfg_pre = 1'b0;
    logic       cfg_man = 1'b0;
    logic       cfg_inv = 1'b0;
    logic       start = 1'b0;
    logic [7:0] len_in = '0;
    logic       ready;
    logic [7:0] byte_data;
    logic       byte_rd;
    logic       tx_line;
    logic       busy;
    logic       done;

    logic [7:0] mem [0:255];
    int         rd_idx = 0;
    logic       rd_clr = 1'b0;
    int         p_cur = 1;
    int         tcnt = 0;
    bit         expb [0:4095];
    int         nexp;
    int         ones;
    int         n_chk = 0;
    int         n_fail = 0;

    hdlc_tx uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_en          (tx_en),
        .cts            (cts),
        .tick16         (tick16),
        .cfg_preamble   (cfg_pre),
        .cfg_manchester (cfg_man),
        .cfg_invert     (cfg_inv),
        .start          (start),
        .len            (len_in),
        .ready          (ready),
        .byte_data      (byte_data),
        .byte_rd        (byte_rd),
        .tx_line        (tx_line),
        .busy           (busy),
        .done           (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign byte_data = mem[rd_idx[7:0]];

    always @(posedge clk) begin
        if (rd_clr) rd_idx <= 0;
        else if (byte_rd) rd_idx <= rd_idx + 1;
    end

    always @(negedge clk) begin
        tcnt = (tcnt + 1 >= p_cur) ? 0 : tcnt + 1;
        tick16 = (tcnt == 0);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic push(input bit b);
        expb[nexp] = b;
        nexp++;
    endtask

    task automatic push_st(input bit b);
        push(b);
        ones = b ? ones + 1 : 0;
        if (ones == 5) begin
            push(1'b0);
            ones = 0;
        end
    endtask

    task automatic fill(input int len, input int kind);
        for (int i = 0; i < 256; i++) begin
            case (kind)
                0: mem[i] = 8'hFF;
                1: mem[i] = 8'(i * 37 + 5);
                2: mem[i] = 8'h7E;
                default: mem[i] = 8'h00;
            endcase
        end
        if (len < 0) mem[0] = 8'h00;
    endtask

    // Expected line bits from the framing rules (R2 R3 R4 R5)
    task automatic build(input int len, input bit pre);
        logic [15:0] crc;
        logic [15:0] fcs;
        logic [7:0]  flag;
        bit          b;
        bit          fb;
        flag = 8'h7E;
        nexp = 0;
        ones = 0;
        if (pre) for (int i = 0; i < 16; i++) push(bit'(i % 2));
        for (int i = 0; i < 8; i++) push(flag[i]);
        crc = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            for (int j = 0; j < 8; j++) begin
                b = mem[i][j];
                fb = crc[0] ^ b;
                crc = crc >> 1;
                if (fb) crc = crc ^ 16'h8408;
                push_st(b);
            end
        end
        fcs = ~crc;
        for (int j = 0; j < 16; j++) push_st(fcs[j]);
        for (int i = 0; i < 8; i++) push(flag[i]);
    endtask

    task automatic configure(input bit pre, input bit man, input bit inv, input int p);
        @(negedge clk);
        tx_en = 1'b0;
        cfg_pre = pre;
        cfg_man = man;
        cfg_inv = inv;
        p_cur = p;
        rd_clr = 1'b1;
        repeat (3) @(negedge clk);
        rd_clr = 1'b0;
        tx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_frame(input int len, input int kind, input bit pre, input bit man,
                             input bit inv, input int p, input int hold, input bit flip,
                             input string lab);
        int  errs;
        int  first_bad;
        int  k;
        int  dcnt;
        int  bad;
        bit  idl;
        bit  exp_line;
        idl = ~inv;
        fill(len, kind);
        build(len, pre);
        configure(pre, man, inv, p);
        if (flip) begin
            cfg_inv = ~inv;
            cfg_man = ~man;
            cfg_pre = ~pre;
        end
        cts = (hold == 0);
        chk(ready == 1'b1, {"R12 ready before start ", lab}, int'(ready), 1);
        start = 1'b1;
        len_in = 8'(len);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R12 busy after start ", lab}, int'(busy), 1);
        if (hold > 0) begin
            bad = 0;
            repeat (hold) begin
                @(negedge clk);
                if (tx_line != idl || busy != 1'b1) bad++;
            end
            chk(bad == 0, {"R9 held by cts ", lab}, bad, 0);
            cts = 1'b1;
        end
        k = 0;
        while (tx_line == idl && k < 64 * p + 200) begin
            @(negedge clk);
            k++;
        end
        chk(tx_line != idl, {"R2 frame start seen ", lab}, int'(tx_line), int'(~idl));
        errs = 0;
        first_bad = -1;
        for (int i = 0; i < nexp; i++) begin
            if (i == 0) begin
                repeat (man ? 4 * p : 8 * p) @(negedge clk);
            end else begin
                repeat (8 * p) @(negedge clk);
                if (man) begin
                    exp_line = ~expb[i] ^ inv;
                    if (tx_line != exp_line) begin
                        errs++;
                        if (first_bad < 0) first_bad = i;
                    end
                end
                repeat (8 * p) @(negedge clk);
            end
            exp_line = expb[i] ^ inv;
            if (tx_line != exp_line) begin
                errs++;
                if (first_bad < 0) first_bad = i;
            end
        end
        chk(errs == 0, {"R2 R4 R5 R6 line bits (first bad index as actual) ", lab}, first_bad, -1);
        dcnt = 0;
        bad = 0;
        for (int i = 0; i < 20 * p + 8; i++) begin
            @(negedge clk);
            if (done) begin
                dcnt++;
                if (tx_line != idl) bad++;
            end
        end
        chk(dcnt == 1, {"R10 single done pulse ", lab}, dcnt, 1);
        chk(bad == 0 && tx_line == idl, {"R10 idle after frame ", lab}, int'(tx_line), int'(idl));
        chk(rd_idx == len, {"R12 bytes fetched ", lab}, rd_idx, len);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        string lab;
        logic [15:0] v;
        int bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(tx_line == 1'b1, "R1 line idle in reset", int'(tx_line), 1);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done low in reset", int'(busy | done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ready == 1'b0, "R1 not ready while disabled", int'(ready), 0);

        // Vector table: patterns and modes
        for (int n = 0; n < NV; n++) begin
            v = VEC[n];
            lab = $sformatf("v%0d%s%s%s", n,
                            v[5] ? " R3" : "", v[4] ? " R7" : "", v[3] ? " R8" : "");
            run_frame(int'(v[15:8]), int'(v[7:6]), v[5], v[4], v[3], int'(v[2:0]), 0, 1'b0, lab);
        end

        // R9: frame held back while cts is low
        run_frame(3, 1, 1'b0, 1'b0, 1'b0, 1, 600, 1'b0, "cts hold R9");

        // R11: mode inputs changed while enabled are ignored
        run_frame(4, 2, 1'b0, 1'b0, 1'b0, 1, 0, 1'b1, "mode change while enabled R11");

        // R13: abort by dropping tx_en mid-frame
        fill(8, 1);
        configure(1'b0, 1'b1, 1'b0, 1);
        start = 1'b1;
        len_in = 8'd8;
        @(negedge clk);
        start = 1'b0;
        repeat (500) @(negedge clk);
        chk(busy == 1'b1, "R13 frame in progress before abort", int'(busy), 1);
        tx_en = 1'b0;
        @(negedge clk);
        chk(tx_line == 1'b1 && busy == 1'b0, "R13 idle right after abort", int'(tx_line), 1);
        bad = 0;
        repeat (100) begin
            @(negedge clk);
            if (tx_line != 1'b1 || done) bad++;
        end
        chk(bad == 0, "R13 stays idle after abort", bad, 0);

        summary();
    end

endmodule